// File: doc/BRIEF.md
# Watchdog Timer with Tap-Selectable Postscaler

This block is a watchdog that runs from a slow, free-running internal clock. A fixed prescaler divides that clock by `PRE_DIV` (128 by default) to form a base tick of roughly 4 ms. A binary postscaler counts base ticks, and a 4-bit select code picks which power-of-two tap ends the timeout. With code N the ratio is 2^N, so the timeout spans from one base tick up to 32,768 base ticks, which is about 4 ms to 135 s.

The watchdog runs when the configuration enable is set. When that enable is clear, software can start it with its own enable. Three requests restart the count from zero: the clear-watchdog instruction, entry into sleep, and a detected clock failure. If the watchdog expires while the device is running, the block emits a one-cycle device-reset pulse. If it expires while the device sleeps, it emits a one-cycle wake-up pulse instead. After either pulse the count restarts from zero.

Top module: `wdog_top`

## Requirements
- R1: The prescaler divides the clock by `PRE_DIV`. With select code N and the watchdog enabled from a zeroed state, the first pulse is high during the cycle that follows the `PRE_DIV`*2^N-th rising edge after enabling.
- R2: The select code N (tap_sel, 0 to 15) sets a postscaler ratio of 2^N. Code 0 expires on every base tick. Code 15 expires after 32,768 base ticks.
- R3: The watchdog is enabled when cfg_en is 1 or sw_en is 1. When cfg_en is 1, changes on sw_en do not affect the expiry timing.
- R4: While the watchdog is disabled, both counters are held at zero and no pulse appears. When it is enabled again, timing restarts from zero.
- R5: A one-cycle high on clr_instr, sleep_enter or clk_fail clears both counters. The next pulse then comes a full timeout after the edge where the clear was taken.
- R6: On expiry with in_sleep at 0, wdt_reset goes high for exactly one cycle and wdt_wake stays low.
- R7: On expiry with in_sleep at 1, wdt_wake goes high for exactly one cycle and wdt_reset stays low.
- R8: After a pulse, both counters restart from zero, so pulses repeat every `PRE_DIV`*2^N cycles.
- R9: If a clear request falls in the same cycle as an expiry, the clear wins: no pulse is issued, and the next timeout starts from zero.
- R10: Asserting rst_n (low) clears both counters and both outputs at once. Release is synchronized over two clock edges, and counting starts on the third edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running low-frequency oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_en | input | 1 | Configuration enable; forces the watchdog on |
| sw_en | input | 1 | Software enable; used only while cfg_en is 0 |
| tap_sel | input | 4 | Postscaler tap code N, ratio 2^N |
| clr_instr | input | 1 | Clear-watchdog instruction strobe |
| sleep_enter | input | 1 | Sleep-instruction strobe; clears the count |
| clk_fail | input | 1 | Clock-failure indication; clears the count |
| in_sleep | input | 1 | Device is in a power-managed sleep mode |
| wdt_reset | output | 1 | One-cycle device-reset request |
| wdt_wake | output | 1 | One-cycle wake-up request |

## Verification
A clear request and an expiry can land in the same cycle, and the clear must then suppress the pulse. The bench forces this case by timing a clear strobe to the last clock cycle of a running timeout, in the same cycle the terminal tap is reached. It then expects no pulse at the usual instant and a pulse exactly one full timeout after that edge. The scoreboard treats any pulse it did not schedule as a failure, so a pulse that leaks through is caught.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Registered expiry event that drives the two output pulses
  typedef enum logic [1:0] {
    WD_IDLE  = 2'd0,
    WD_RESET = 2'd1,
    WD_WAKE  = 2'd2
  } wd_evt_e;

  // Pick the pulse kind for an expiry, or idle when there is none
  function automatic wd_evt_e wd_classify(input logic expire, input logic asleep);
    if (!expire)     return WD_IDLE;
    else if (asleep) return WD_WAKE;
    else             return WD_RESET;
  endfunction

endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl (
  input  logic cfg_en,
  input  logic sw_en,
  input  logic clr_instr,
  input  logic sleep_enter,
  input  logic clk_fail,
  output logic run,
  output logic clr
);

  logic sw_path;

  always_comb begin
    // The software enable matters only while the configuration bit is off
    sw_path = ~cfg_en & sw_en;
    run     = cfg_en | sw_path;
    clr     = clr_instr | sleep_enter | clk_fail;
  end

endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int PRE_DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);

  localparam int PW = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          at_last;
  logic          hold;

  always_comb begin
    at_last = (cnt_q == LAST);
    hold    = ~run | clr;
    tick    = ~hold & at_last;
    if (hold)         cnt_d = '0;
    else if (at_last) cnt_d = '0;
    else              cnt_d = cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4
  presc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

  // R1
  presc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));

endmodule

// File: rtl/wdog_postscale.sv
module wdog_postscale #(
  parameter int POST_W = 16,
  parameter int SEL_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             tick,
  input  logic [SEL_W-1:0] tap_sel,
  output logic             expire
);

  localparam int CNT_W = POST_W - 1;
  localparam int NTAP  = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NTAP-1:0]  term_vec;
  logic             at_term;

  // Tap i is terminal once the lower i count bits are all ones
  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    if (i == 0) begin : g_first
      assign term_vec[i] = 1'b1;
    end else begin : g_rest
      assign term_vec[i] = &cnt_q[i-1:0];
    end
  end

  always_comb begin
    at_term = term_vec[tap_sel];
    expire  = tick & at_term & ~clr;
    if (~run | clr)   cnt_d = '0;
    else if (expire)  cnt_d = '0;
    else if (tick)    cnt_d = cnt_q + CNT_W'(1);
    else              cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8
  post_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == '0));

  // R4
  post_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

  // R5
  post_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/wdog_top.sv
module wdog_top #(
  parameter int PRE_DIV = 128,
  parameter int POST_W  = 16,
  parameter int SEL_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             sw_en,
  input  logic [SEL_W-1:0] tap_sel,
  input  logic             clr_instr,
  input  logic             sleep_enter,
  input  logic             clk_fail,
  input  logic             in_sleep,
  output logic             wdt_reset,
  output logic             wdt_wake
);

  import wdog_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_i;
  logic       run, clr, tick, expire;
  wd_evt_e    evt_q, evt_d;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  wdog_ctrl u_ctrl (
    .cfg_en      (cfg_en),
    .sw_en       (sw_en),
    .clr_instr   (clr_instr),
    .sleep_enter (sleep_enter),
    .clk_fail    (clk_fail),
    .run         (run),
    .clr         (clr)
  );

  wdog_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk   (clk),
    .rst_n (rst_i),
    .run   (run),
    .clr   (clr),
    .tick  (tick)
  );

  wdog_postscale #(.POST_W(POST_W), .SEL_W(SEL_W)) u_post (
    .clk     (clk),
    .rst_n   (rst_i),
    .run     (run),
    .clr     (clr),
    .tick    (tick),
    .tap_sel (tap_sel),
    .expire  (expire)
  );

  always_comb begin
    evt_d = wd_classify(expire, in_sleep);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) evt_q <= WD_IDLE;
    else        evt_q <= evt_d;
  end

  assign wdt_reset = (evt_q == WD_RESET);
  assign wdt_wake  = (evt_q == WD_WAKE);

  // R6
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_i)
    wdt_reset |=> !wdt_reset);

  // R7
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_i)
    wdt_wake |-> $past(in_sleep));

  // R9
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_i)
    clr |=> !(wdt_reset || wdt_wake));

  // R4
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !run |=> !(wdt_reset || wdt_wake));

endmodule

// File: tb/wdog_top_test.sv
`timescale 1ns/1ps
module wdog_top_test;

  localparam int PDIV = 2;   // short prescaler so the widest tap fits the run

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0, sw_en = 1'b0;
  logic [3:0] tap_sel = 4'd0;
  logic       clr_instr = 1'b0, sleep_enter = 1'b0, clk_fail = 1'b0, in_sleep = 1'b0;
  logic       wdt_reset, wdt_wake;

  int tests = 0, fails = 0, unexp = 0, cyc = 0;
  int    exp_cyc[$];
  bit    exp_wake[$];
  string exp_req[$];

  wdog_top #(.PRE_DIV(PDIV)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .sw_en(sw_en), .tap_sel(tap_sel),
    .clr_instr(clr_instr), .sleep_enter(sleep_enter), .clk_fail(clk_fail),
    .in_sleep(in_sleep), .wdt_reset(wdt_reset), .wdt_wake(wdt_wake)
  );

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops scheduled pulses and compares them as they come due
  always @(negedge clk) begin
    if (exp_cyc.size() > 0 && cyc == exp_cyc[0]) begin
      tests++;
      if (wdt_reset !== !exp_wake[0] || wdt_wake !== exp_wake[0]) begin
        fails++;
        $display("FAIL %s cycle %0d: reset=%b wake=%b, expected reset=%b wake=%b",
                 exp_req[0], cyc, wdt_reset, wdt_wake, !exp_wake[0], exp_wake[0]);
      end
      void'(exp_cyc.pop_front()); void'(exp_wake.pop_front()); void'(exp_req.pop_front());
    end else if (wdt_reset === 1'b1 || wdt_wake === 1'b1) begin
      unexp++;
      tests++; fails++;
      $display("FAIL unscheduled pulse cycle %0d: reset=%b wake=%b, expected none",
               cyc, wdt_reset, wdt_wake);
    end
  end

  task automatic push(input int c, input bit wake, input string req);
    exp_cyc.push_back(c); exp_wake.push_back(wake); exp_req.push_back(req);
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic start(input bit cfg, input bit sw, input int sel, input bit slp, output int s);
    @(negedge clk);
    cfg_en = cfg; sw_en = sw; tap_sel = 4'(sel); in_sleep = slp;
    s = cyc;
  endtask

  task automatic stop_and_drain(input string req);
    @(negedge clk);
    cfg_en = 0; sw_en = 0; in_sleep = 0;
    repeat (4) @(negedge clk);
    tests++;
    if (exp_cyc.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d scheduled pulses missing, expected 0", req, exp_cyc.size());
      exp_cyc.delete(); exp_wake.delete(); exp_req.delete();
    end
  endtask

  task automatic strobe(input int which);
    case (which)
      0: clr_instr = 1;
      1: sleep_enter = 1;
      default: clk_fail = 1;
    endcase
    @(negedge clk);
    clr_instr = 0; sleep_enter = 0; clk_fail = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : driver
    int s, u0;
    repeat (3) @(negedge clk);
    tests++;   // R10 reset state
    if (wdt_reset !== 0 || wdt_wake !== 0) begin
      fails++;
      $display("FAIL R10 reset: reset=%b wake=%b, expected 0 0", wdt_reset, wdt_wake);
    end
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R1 R2 R6 R8: code 0 pulses every base tick
    start(1, 0, 0, 0, s);
    push(s + PDIV, 0, "R1"); push(s + 2*PDIV, 0, "R8"); push(s + 3*PDIV, 0, "R6");
    wait_to(s + 3*PDIV);
    stop_and_drain("R2");

    // R1 R8: code 3
    start(1, 0, 3, 0, s);
    push(s + 8*PDIV, 0, "R1"); push(s + 16*PDIV, 0, "R8");
    wait_to(s + 16*PDIV);
    stop_and_drain("R1");

    // R7: sleeping device gets a wake pulse
    start(1, 0, 2, 1, s);
    push(s + 4*PDIV, 1, "R7"); push(s + 8*PDIV, 1, "R7");
    wait_to(s + 8*PDIV);
    stop_and_drain("R7");

    // R4: disabled watchdog stays quiet
    u0 = unexp;
    start(0, 0, 0, 0, s);
    repeat (50) @(negedge clk);
    tests++;
    if (unexp != u0) begin
      fails++;
      $display("FAIL R4 disabled: %0d pulses, expected 0", unexp - u0);
    end

    // R3: software enable starts it when the configuration bit is off
    start(0, 1, 1, 0, s);
    push(s + 2*PDIV, 0, "R3");
    wait_to(s + 2*PDIV);
    stop_and_drain("R3");

    // R3: toggling sw_en with cfg_en set does not disturb timing
    start(1, 0, 2, 0, s);
    push(s + 4*PDIV, 0, "R3"); push(s + 8*PDIV, 0, "R3");
    wait_to(s + 3); sw_en = 1;
    wait_to(s + 5); sw_en = 0;
    wait_to(s + 8*PDIV);
    stop_and_drain("R3");

    // R4: disable mid-count then re-enable restarts from zero
    start(1, 0, 3, 0, s);
    wait_to(s + 10); cfg_en = 0;
    wait_to(s + 13); cfg_en = 1;
    push(s + 13 + 8*PDIV, 0, "R4");
    wait_to(s + 13 + 8*PDIV);
    stop_and_drain("R4");

    // R5: each clear source restarts the count
    for (int k = 0; k < 3; k++) begin
      start(1, 0, 3, 0, s);
      wait_to(s + 12);
      strobe(k);
      push(s + 13 + 8*PDIV, 0, "R5");
      wait_to(s + 13 + 8*PDIV);
      stop_and_drain("R5");
    end

    // R9: clear in the expiry cycle suppresses the pulse
    start(1, 0, 1, 0, s);
    push(s + 2*PDIV, 0, "R9");
    wait_to(s + 4*PDIV - 1);
    strobe(0);
    push(s + 4*PDIV + 2*PDIV, 0, "R9");
    wait_to(s + 6*PDIV);
    stop_and_drain("R9");

    // R10: reset mid-count, counting resumes after synchronized release
    start(1, 0, 2, 0, s);
    wait_to(s + 5); rst_n = 0;
    @(negedge clk);
    tests++;
    if (wdt_reset !== 0 || wdt_wake !== 0) begin
      fails++;
      $display("FAIL R10 in reset: reset=%b wake=%b, expected 0 0", wdt_reset, wdt_wake);
    end
    @(negedge clk); rst_n = 1; s = cyc;
    push(s + 2 + 4*PDIV, 0, "R10");
    wait_to(s + 2 + 4*PDIV);
    stop_and_drain("R10");

    // R2: widest tap, 32768 base ticks
    start(1, 0, 15, 0, s);
    push(s + 32768*PDIV, 0, "R2");
    wait_to(s + 32768*PDIV);
    stop_and_drain("R2");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule